// File: doc/BRIEF.md
# SAR Converter Conversion and Readout Controller

This block runs a serial successive-approximation converter that has one conversion-start line and no separate select line. When a sample request arrives, the controller drives the start line high. It keeps the line high for the worst-case conversion time. It then drives the line low, which lets the converter drive its serial output. The controller then sends a gated serial clock and shifts in the result with the most significant bit first. When the last bit is in, it presents the assembled word together with a one-cycle valid strobe.

Several converters can be daisy-chained, each passing its serial input through to the next. The controller reads such a chain as one long shift of `CHAIN_N` × `SAMPLE_BITS` bits, and the converter wired directly to the controller arrives first. All timing is set by parameters counted in system-clock cycles:

- the shortest start pulse;
- the conversion wait;
- the serial-clock half period;
- the shortest spacing between two conversion starts.

A request that arrives too early is not lost. The controller holds it and serves it as soon as the spacing rule allows.

Top module: `sar_readout_ctrl`

## Requirements
- R1: While reset is asserted, and afterwards until a request arrives, `cnv_o`, `sck_o` and `data_valid_o` are all low.
- R2: A request seen in idle raises `cnv_o` on the next clock edge. `cnv_o` then stays high for exactly `CONV_CYC` cycles, which covers both the shortest start pulse (`CNVH_CYC`) and the conversion wait.
- R3: `sck_o` never pulses while `cnv_o` is high. Each conversion gives exactly `CHAIN_N*SAMPLE_BITS` rising edges on `sck_o`.
- R4: During readout, every high phase and every low phase of `sck_o` between pulses lasts exactly `SCK_HALF` cycles. `sck_o` rests low outside readout.
- R5: `sdo_i` is captured on each rising edge of `sck_o`. The first bit captured ends up in bit `CHAIN_N*SAMPLE_BITS-1` of `data_o` and the last in bit 0, so the converter nearest the controller fills the top `SAMPLE_BITS` bits.
- R6: `data_valid_o` is high for exactly one cycle per conversion. It rises on the edge that ends the last serial-clock pulse, `CONV_CYC + 2*SCK_HALF*CHAIN_N*SAMPLE_BITS` cycles after `cnv_o` rose. `data_o` holds its word until the next readout starts.
- R7: Two rising edges of `cnv_o` are never closer than `CYCLE_CYC` cycles. A request made earlier is held, and `cnv_o` rises exactly `CYCLE_CYC` cycles after the previous rise when readout has already ended.
- R8: Any number of requests made while a conversion is in progress collapse into a single further conversion.
- R9: Asserting reset in the middle of a conversion drops `cnv_o` and `sck_o` at once. No valid strobe and no new conversion follow until the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, releases synchronously |
| start_req | input | 1 | Sample request; held until it can be served |
| sdo_i | input | 1 | Serial data from the converter (or the nearest converter of a chain) |
| cnv_o | output | 1 | Conversion-start line; high from conversion start to conversion end, low during readout |
| sck_o | output | 1 | Serial clock to the converter(s); rests low |
| data_o | output | CHAIN_N*SAMPLE_BITS | Assembled result; first captured bit is the MSB |
| data_valid_o | output | 1 | One-cycle strobe marking a new word on `data_o` |

## Verification
A wrong state timer shows up at the ports within the first conversion. The high time of `cnv_o` differs from `CONV_CYC`, or the strobe lands away from its fixed offset after the rise, so the bench measures both to the cycle. A wrong phase or bit counter shows up in the same readout, as a changed count of serial-clock pulses, a changed phase length, or a word that is shifted or reversed. The bench's converter model makes each such fault visible as a data mismatch. A held-request or spacing fault appears only on the second conversion of a back-to-back pair, so the bench issues requests immediately after each strobe and checks the exact gap between rises.

// File: rtl/sar_ctrl_pkg.sv
package sar_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_CNV_HI    = 3'd1,
    ST_CONV_WAIT = 3'd2,
    ST_SHIFT     = 3'd3,
    ST_DONE      = 3'd4
  } sar_state_t;

  function automatic bit cnv_level(input sar_state_t st);
    return (st == ST_CNV_HI) || (st == ST_CONV_WAIT);
  endfunction

endpackage

// File: rtl/sar_interval_cnt.sv
module sar_interval_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero_o
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/sar_sck_gen.sv
module sar_sck_gen #(
  parameter int SCK_HALF = 2,
  parameter int BITS     = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sck_o,
  output logic sample_stb,
  output logic last_fall
);

  localparam int PW = (2 * SCK_HALF > 2) ? $clog2(2 * SCK_HALF) : 1;
  localparam int BW = (BITS > 2) ? $clog2(BITS) : 1;
  localparam logic [PW-1:0] PH_RISE = PW'(SCK_HALF - 1);
  localparam logic [PW-1:0] PH_HIGH = PW'(SCK_HALF);
  localparam logic [PW-1:0] PH_LAST = PW'(2 * SCK_HALF - 1);
  localparam logic [BW-1:0] BIT_LAST = BW'(BITS - 1);

  logic [PW-1:0] ph_q, ph_d;
  logic [BW-1:0] bit_q, bit_d;
  logic          sck_q, sck_d;
  logic          wrap;

  always_comb begin
    wrap  = (ph_q == PH_LAST);
    ph_d  = '0;
    bit_d = '0;
    sck_d = 1'b0;
    if (run) begin
      ph_d  = wrap ? '0 : (ph_q + 1'b1);
      bit_d = wrap ? (bit_q + 1'b1) : bit_q;
      sck_d = (ph_d >= PH_HIGH);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= '0;
      bit_q <= '0;
      sck_q <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      bit_q <= bit_d;
      sck_q <= sck_d;
    end
  end

  assign sck_o      = sck_q;
  assign sample_stb = run && (ph_q == PH_RISE);
  assign last_fall  = run && wrap && (bit_q == BIT_LAST);

endmodule

// File: rtl/sar_shift_rx.sv
module sar_shift_rx #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         bit_in,
  output logic [W-1:0] data_o
);

  logic [W-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
    end else if (shift_en) begin
      sr_q <= {sr_q[W-2:0], bit_in};
    end
  end

  assign data_o = sr_q;

endmodule

// File: rtl/sar_readout_ctrl.sv
module sar_readout_ctrl #(
  parameter int SAMPLE_BITS = 16,
  parameter int CHAIN_N     = 1,
  parameter int SCK_HALF    = 2,
  parameter int CNVH_CYC    = 2,
  parameter int CONV_CYC    = 160,
  parameter int CYCLE_CYC   = 200
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           start_req,
  input  logic                           sdo_i,
  output logic                           cnv_o,
  output logic                           sck_o,
  output logic [CHAIN_N*SAMPLE_BITS-1:0] data_o,
  output logic                           data_valid_o
);
  import sar_ctrl_pkg::*;

  localparam int TOTAL_BITS = CHAIN_N * SAMPLE_BITS;
  localparam int WAIT_CYC   = CONV_CYC - CNVH_CYC;
  localparam int TW         = $clog2(CONV_CYC + 1);
  localparam int CW         = $clog2(CYCLE_CYC + 1);
  localparam logic [TW-1:0] HI_LOAD   = TW'(CNVH_CYC - 1);
  localparam logic [TW-1:0] WAIT_LOAD = TW'(WAIT_CYC - 1);
  localparam logic [CW-1:0] CYC_LOAD  = CW'(CYCLE_CYC - 1);

  // reset: asynchronous assertion, synchronous release
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  sar_state_t state_q, state_d;
  logic       pend_q, pend_d;
  logic       cnv_q, cnv_d;
  logic       launch;
  logic       st_load;
  logic [TW-1:0] st_val;
  logic       st_zero;
  logic       cyc_ready;
  logic       run_shift;
  logic       sample_stb;
  logic       last_fall;

  // state duration timer (start pulse, conversion wait)
  sar_interval_cnt #(.W(TW)) u_state_tmr (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (st_load),
    .load_val (st_val),
    .zero_o   (st_zero)
  );

  // spacing timer between conversion starts
  sar_interval_cnt #(.W(CW)) u_cycle_tmr (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (launch),
    .load_val (CYC_LOAD),
    .zero_o   (cyc_ready)
  );

  assign run_shift = (state_q == ST_SHIFT);

  sar_sck_gen #(.SCK_HALF(SCK_HALF), .BITS(TOTAL_BITS)) u_sck (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .run        (run_shift),
    .sck_o      (sck_o),
    .sample_stb (sample_stb),
    .last_fall  (last_fall)
  );

  sar_shift_rx #(.W(TOTAL_BITS)) u_rx (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .shift_en (sample_stb),
    .bit_in   (sdo_i),
    .data_o   (data_o)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    st_load = 1'b0;
    st_val  = HI_LOAD;
    launch  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if ((pend_q || start_req) && cyc_ready) begin
          launch  = 1'b1;
          st_load = 1'b1;
          st_val  = HI_LOAD;
          state_d = ST_CNV_HI;
        end
      end
      ST_CNV_HI: begin
        if (st_zero) begin
          st_load = 1'b1;
          st_val  = WAIT_LOAD;
          state_d = ST_CONV_WAIT;
        end
      end
      ST_CONV_WAIT: begin
        if (st_zero) state_d = ST_SHIFT;
      end
      ST_SHIFT: begin
        if (last_fall) state_d = ST_DONE;
      end
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
    pend_d = (pend_q || start_req) && !launch;
    cnv_d  = cnv_level(state_d);
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
      pend_q  <= 1'b0;
      cnv_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      cnv_q   <= cnv_d;
    end
  end

  assign cnv_o        = cnv_q;
  assign data_valid_o = (state_q == ST_DONE);

endmodule

// File: rtl/sar_ctrl_chk.sv
module sar_ctrl_chk #(
  parameter int CONV_CYC  = 160,
  parameter int CYCLE_CYC = 200
) (
  input logic clk,
  input logic rst_n,
  input logic cnv_o,
  input logic sck_o,
  input logic data_valid_o
);

  localparam int HW = $clog2(CONV_CYC + 2);
  localparam int GW = $clog2(CYCLE_CYC + 2);
  localparam logic [HW-1:0] HMAX = HW'(CONV_CYC);
  localparam logic [GW-1:0] GMAX = GW'(CYCLE_CYC);

  logic [HW-1:0] hi_run;
  logic [GW-1:0] gap;
  logic          cnv_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run <= '0;
      gap    <= GMAX;
      cnv_p  <= 1'b0;
    end else begin
      cnv_p <= cnv_o;
      if (!cnv_o) hi_run <= '0;
      else if (hi_run != HMAX) hi_run <= hi_run + 1'b1;
      if (cnv_o && !cnv_p) gap <= GW'(1);
      else if (gap != GMAX) gap <= gap + 1'b1;
    end
  end

  AST_CNV_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cnv_o) |-> (hi_run >= HMAX)); // R2
  AST_NO_SCK_IN_CNV: assert property (@(posedge clk) disable iff (!rst_n)
    !(cnv_o && sck_o)); // R3
  AST_VALID_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid_o |=> !data_valid_o); // R6
  AST_VALID_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid_o |-> (!cnv_o && !sck_o)); // R6
  AST_START_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cnv_o) |-> (gap >= GMAX)); // R7

endmodule

bind sar_readout_ctrl sar_ctrl_chk #(
  .CONV_CYC  (CONV_CYC),
  .CYCLE_CYC (CYCLE_CYC)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cnv_o        (cnv_o),
  .sck_o        (sck_o),
  .data_valid_o (data_valid_o)
);

// File: tb/sim_sar_readout_ctrl.sv
`timescale 1ns/1ps
module sim_sar_readout_ctrl;

  localparam int BITS   = 16;
  localparam int CHAIN  = 2;
  localparam int HALF   = 2;
  localparam int CNVH   = 2;
  localparam int CONV   = 160;
  localparam int CYCLE  = 400;
  localparam int TOTAL  = BITS * CHAIN;
  localparam int LATENCY = CONV + 2 * HALF * TOTAL;
  localparam int NVEC = 7;
  localparam logic [31:0] VEC [0:NVEC-1] = '{
    32'h0000_FFFF, 32'hFFFF_0000, 32'hA5A5_5A5A, 32'h8000_0001,
    32'h1234_ABCD, 32'hFFFF_FFFF, 32'h0000_0000
  };

  logic clk = 1'b0;
  logic rst_n;
  logic start_req;
  logic sdo_i;
  logic cnv_o, sck_o, data_valid_o;
  logic [TOTAL-1:0] data_o;

  always #5 clk = ~clk;

  sar_readout_ctrl #(
    .SAMPLE_BITS(BITS), .CHAIN_N(CHAIN), .SCK_HALF(HALF),
    .CNVH_CYC(CNVH), .CONV_CYC(CONV), .CYCLE_CYC(CYCLE)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .sdo_i(sdo_i),
    .cnv_o(cnv_o), .sck_o(sck_o), .data_o(data_o), .data_valid_o(data_valid_o)
  );

  // behavioural two-converter chain; dev0 is wired to the controller
  logic [15:0] pat0, pat1, m0, m1;
  always @(posedge cnv_o) begin
    m0 <= pat0;
    m1 <= pat1;
  end
  always @(negedge sck_o) begin
    m0 <= {m0[14:0], m1[15]};
    m1 <= {m1[14:0], 1'b0};
  end
  assign sdo_i = m0[15];

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  // port monitor, sampled away from the active edge
  int cyc = 0, rise_cyc = 0, last_gap = 0, hi_len = 0, valid_cyc = 0;
  int total_rises = 0, valid_total = 0, sck_rises = 0, overlap = 0;
  int run_len = 0, hi_min = 0, hi_max = 0, lo_min = 0, lo_max = 0;
  bit have_rise = 0;
  logic cnv_p = 0, sck_p = 0;

  always @(negedge clk) begin
    cyc++;
    if (cnv_o && !cnv_p) begin
      if (have_rise) last_gap = cyc - rise_cyc;
      rise_cyc = cyc; have_rise = 1; total_rises++;
      sck_rises = 0; hi_min = 9999; hi_max = 0; lo_min = 9999; lo_max = 0;
    end
    if (!cnv_o && cnv_p) hi_len = cyc - rise_cyc;
    if (cnv_o && sck_o) overlap++;
    if (sck_o == sck_p) run_len++;
    else begin
      if (sck_p) begin
        if (run_len < hi_min) hi_min = run_len;
        if (run_len > hi_max) hi_max = run_len;
      end else if (sck_rises > 0) begin
        if (run_len < lo_min) lo_min = run_len;
        if (run_len > lo_max) lo_max = run_len;
      end
      run_len = 1;
    end
    if (sck_o && !sck_p) sck_rises++;
    if (data_valid_o) begin valid_total++; valid_cyc = cyc; end
    cnv_p = cnv_o; sck_p = sck_o;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic pulse_req();
    @(negedge clk) start_req = 1'b1;
    @(negedge clk) start_req = 1'b0;
  endtask

  task automatic wait_valid(output bit seen);
    seen = 0;
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk); #1;
      if (data_valid_o) begin seen = 1; break; end
    end
  endtask

  task automatic run_one(input logic [31:0] exp, input bit gap_chk);
    bit seen;
    logic [31:0] held;
    pat0 = exp[31:16]; pat1 = exp[15:0];
    pulse_req();
    wait_valid(seen);
    chk(seen, "R6", "valid seen", seen, 1);
    chk(data_o == exp, "R5", "word", data_o, exp);
    chk(valid_cyc - rise_cyc == LATENCY, "R6", "valid latency", valid_cyc - rise_cyc, LATENCY);
    chk(hi_len == CONV, "R2", "cnv high cycles", hi_len, CONV);
    chk(sck_rises == TOTAL && overlap == 0, "R3", "sck pulses", sck_rises, TOTAL);
    chk(hi_min == HALF && hi_max == HALF, "R4", "sck high phase", hi_max, HALF);
    chk(lo_min == HALF && lo_max == HALF, "R4", "sck low phase", lo_max, HALF);
    if (gap_chk) chk(last_gap == CYCLE, "R7", "start spacing", last_gap, CYCLE);
    held = data_o;
    @(negedge clk); #1;
    chk(!data_valid_o, "R6", "valid one cycle", data_valid_o, 0);
    repeat (5) @(negedge clk);
    #1 chk(data_o == held && !sck_o, "R6", "word held", data_o, held);
  endtask

  initial begin
    bit seen;
    int r0, v0;
    rst_n = 1'b0; start_req = 1'b0; pat0 = '0; pat1 = '0;
    repeat (3) @(negedge clk);
    chk(!cnv_o && !sck_o && !data_valid_o, "R1", "reset outputs",
        {cnv_o, sck_o, data_valid_o}, 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    #1 chk(total_rises == 0 && !cnv_o && !sck_o && valid_total == 0, "R1",
           "idle without request", total_rises, 0);

    // vector table: requests right after each strobe
    for (int i = 0; i < NVEC; i++) run_one(VEC[i], i > 0);

    // R8: several requests during one conversion collapse into one more
    repeat (500) @(negedge clk);
    r0 = total_rises;
    pat0 = 16'hC3C3; pat1 = 16'h0F0F;
    pulse_req();
    repeat (20) @(negedge clk);
    pulse_req();
    repeat (7) @(negedge clk);
    pulse_req();
    wait_valid(seen);
    wait_valid(seen);
    chk(seen && data_o == 32'hC3C3_0F0F, "R8", "held request served", data_o, 32'hC3C3_0F0F);
    repeat (600) @(negedge clk);
    chk(total_rises - r0 == 2, "R8", "conversions for burst", total_rises - r0, 2);

    // R9: reset mid-readout
    pat0 = 16'h5555; pat1 = 16'hAAAA;
    pulse_req();
    repeat (200) @(negedge clk);
    rst_n = 1'b0;
    #1 chk(!cnv_o && !sck_o && !data_valid_o, "R9", "outputs on abort",
           {cnv_o, sck_o, data_valid_o}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    r0 = total_rises; v0 = valid_total;
    repeat (500) @(negedge clk);
    chk(valid_total == v0 && total_rises == r0, "R9", "quiet after abort",
        valid_total - v0, 0);
    run_one(32'h5555_AAAA, 1'b0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule